// File: doc/BRIEF.md
# Memory ordering group tracker

This block sits at the front of a load/store unit. Every memory operation that enters the unit is placed into an ordering group, and each group carries a small dependency list. Consecutive plain loads share a group and may run in any order among themselves. A store always gets a group of its own. An operation marked as a barrier forces later loads into a fresh group that waits behind it. A group may issue its members only once every group it depends on has fully executed.

The block also keeps the load-queue and store-queue occupancy. A slot is taken when an operation is admitted and given back only when it retires. When an operation cannot be admitted, the block says why. Dispatch, execute-done and retire each arrive on a separate valid-qualified port and are applied on the same clock edge. A query port reports whether a given group is still live and whether it may issue. A mode input drops the edge from a store group to a later load group, for use when loads and stores are known never to overlap.

Top module: `mem_order_tracker`

## Requirements
- R1: Admission rules:
  - An operation with the load flag needs a free load-queue slot, and one with the store flag needs a free store-queue slot. An operation with both flags needs both.
  - `disp_status` is 0 on admission, 1 when the load queue is full, 2 when the store queue is full and 3 when the group table is full. The checks are made in that order, so load-queue-full wins over store-queue-full.
  - A retire in the same cycle frees its slot before the check.
- R2: Each queue count rises by one on every admitted operation that uses that queue and falls by one on every retire that names that queue. An execute-done never changes either count.
- R3: After reset, group identifiers are handed out as 1, 2, 3 and so on, one per newly opened group. `disp_gid` gives the identifier in the same cycle as the dispatch.
- R4: Every store opens a new group. That group depends on the current store group and on the younger of the current load group and the current load-barrier group, when those are nonzero. A store with the load flag also becomes the current load group, and when it is marked barrier it also becomes the current load-barrier group.
- R5: A load opens a new group in any of these cases:
  - there is no current load group;
  - the load is a barrier;
  - the current load group is not newer than the current store group;
  - the current load group is not newer than the current load-barrier group.
  Otherwise the load joins the current load group, and `disp_new` is 0.
- R6: A newly opened load group depends on the current load-barrier group, when there is one. `qry_ready` is 1 only for a live group whose predecessor groups have all been freed.
- R7: When `no_alias` is 1, a newly opened load group does not depend on the current store group.
- R8: A group is freed once all of its members have executed, and from then on `qry_live` is 0 for it. Any current load, store or load-barrier register that holds its identifier is cleared to 0.
- R9: An operation that would open a group while all table entries are live gets status 3. An entry freed in the same cycle is reusable only from the next cycle.
- R10: An execute-done in the same cycle as a dispatch takes effect first. A load whose current group completes in that cycle opens a new group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| no_alias | input | 1 | Drop store-to-load group edges |
| disp_valid | input | 1 | Dispatch request |
| disp_load | input | 1 | Operation reads memory |
| disp_store | input | 1 | Operation writes memory |
| disp_barrier | input | 1 | Operation is an ordering barrier |
| disp_accept | output | 1 | Dispatch admitted this cycle |
| disp_status | output | 2 | 0 ok, 1 load queue full, 2 store queue full, 3 table full |
| disp_new | output | 1 | Operation opens a new group |
| disp_gid | output | ID_W | Group identifier of the operation |
| exec_valid | input | 1 | One member finished executing |
| exec_gid | input | ID_W | Group of the executed member |
| ret_valid | input | 1 | One operation retires |
| ret_load | input | 1 | Retiring operation held a load slot |
| ret_store | input | 1 | Retiring operation held a store slot |
| qry_gid | input | ID_W | Group to inspect |
| qry_live | output | 1 | Inspected group is live |
| qry_ready | output | 1 | Inspected group may issue |
| lq_count | output | clog2(LQ_DEPTH+1) | Load-queue slots in use |
| sq_count | output | clog2(SQ_DEPTH+1) | Store-queue slots in use |

## Verification
A wrong member count or a lost successor edge shows up at the query port. A group either stays live after its last member has executed, or it never becomes ready. The effect is visible on the cycle after the execute-done that should have freed or unblocked it. A stale current-group register shows up on the very next dispatch, as a wrong `disp_new` or `disp_gid`. Slot counting errors show up as an admission that should have been refused, or as a refusal with a wrong status code, in the same cycle.

// File: rtl/mot_pkg.sv
package mot_pkg;
    typedef enum logic [1:0] {
        DS_OK       = 2'd0,
        DS_LQ_FULL  = 2'd1,
        DS_SQ_FULL  = 2'd2,
        DS_TBL_FULL = 2'd3
    } dstat_e;
endpackage

// File: rtl/mot_slot_counter.sv
module mot_slot_counter #(
    parameter int DEPTH = 12,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          inc,
    input  logic          dec,
    output logic [CW-1:0] count,
    output logic          full_after_dec
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (inc && !dec) cnt_d = cnt_q + CW'(1);
        if (dec && !inc) cnt_d = cnt_q - CW'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign count          = cnt_q;
    assign full_after_dec = (cnt_q == CW'(DEPTH)) && !dec;
endmodule

// File: rtl/mot_grp_lookup.sv
module mot_grp_lookup #(
    parameter int N    = 16,
    parameter int ID_W = 16,
    localparam int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]           live,
    input  logic [N-1:0][ID_W-1:0] ids,
    input  logic [ID_W-1:0]        key,
    output logic                   hit,
    output logic [IDX_W-1:0]       idx
);
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (live[i] && ids[i] == key) begin
                hit = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/mot_group_decider.sv
module mot_group_decider
    import mot_pkg::*;
#(
    parameter int ID_W = 16
) (
    input  logic            is_load,
    input  logic            is_store,
    input  logic            is_bar,
    input  logic            no_alias,
    input  logic [ID_W-1:0] cur_ld,
    input  logic [ID_W-1:0] cur_st,
    input  logic [ID_W-1:0] cur_bar,
    input  logic            lq_full,
    input  logic            sq_full,
    input  logic            free_any,
    output dstat_e          status,
    output logic            open_new,
    output logic [ID_W-1:0] dep_a,
    output logic [ID_W-1:0] dep_b
);
    logic [ID_W-1:0] ld_dom;

    always_comb begin
        ld_dom   = (cur_ld > cur_bar) ? cur_ld : cur_bar;
        open_new = is_store || is_bar || (cur_ld == '0) ||
                   (cur_ld <= cur_st) || (cur_ld <= cur_bar);
        dep_a = '0;
        dep_b = '0;
        if (is_store) begin
            dep_a = cur_st;
            dep_b = ld_dom;
        end else if (open_new) begin
            dep_a = no_alias ? '0 : cur_st;
            dep_b = cur_bar;
        end
        if (is_load && lq_full)       status = DS_LQ_FULL;
        else if (is_store && sq_full) status = DS_SQ_FULL;
        else if (open_new && !free_any) status = DS_TBL_FULL;
        else                          status = DS_OK;
    end
endmodule

// File: rtl/mem_order_tracker.sv
module mem_order_tracker
    import mot_pkg::*;
#(
    parameter int LQ_DEPTH = 12,
    parameter int SQ_DEPTH = 12,
    parameter int GROUPS   = 16,
    parameter int ID_W     = 16
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          no_alias,
    input  logic                          disp_valid,
    input  logic                          disp_load,
    input  logic                          disp_store,
    input  logic                          disp_barrier,
    output logic                          disp_accept,
    output logic [1:0]                    disp_status,
    output logic                          disp_new,
    output logic [ID_W-1:0]               disp_gid,
    input  logic                          exec_valid,
    input  logic [ID_W-1:0]               exec_gid,
    input  logic                          ret_valid,
    input  logic                          ret_load,
    input  logic                          ret_store,
    input  logic [ID_W-1:0]               qry_gid,
    output logic                          qry_live,
    output logic                          qry_ready,
    output logic [$clog2(LQ_DEPTH+1)-1:0] lq_count,
    output logic [$clog2(SQ_DEPTH+1)-1:0] sq_count
);
    localparam int IDX_W  = $clog2(GROUPS);
    localparam int OUT_W  = $clog2(LQ_DEPTH + SQ_DEPTH + 1);
    localparam int PRED_W = 2;
    localparam int NLK    = 5;
    localparam int LK_EXEC = 0;
    localparam int LK_JOIN = 1;
    localparam int LK_DEPA = 2;
    localparam int LK_DEPB = 3;
    localparam int LK_QRY  = 4;

    typedef struct packed {
        logic [GROUPS-1:0]              vld;
        logic [GROUPS-1:0][ID_W-1:0]    gid;
        logic [GROUPS-1:0][OUT_W-1:0]   outst;
        logic [GROUPS-1:0][PRED_W-1:0]  npred;
        logic [GROUPS-1:0][GROUPS-1:0]  succ;
        logic [ID_W-1:0]                cur_ld;
        logic [ID_W-1:0]                cur_st;
        logic [ID_W-1:0]                cur_bar;
        logic [ID_W-1:0]                next_id;
    } state_t;

    state_t s_d, s_q;

    // Lookups of group identifiers into table slots
    logic [NLK-1:0][ID_W-1:0]  lk_key;
    logic [NLK-1:0]            lk_hit;
    logic [NLK-1:0][IDX_W-1:0] lk_idx;

    for (genvar g = 0; g < NLK; g++) begin : g_lookup
        mot_grp_lookup #(.N(GROUPS), .ID_W(ID_W)) u_lookup (
            .live (s_q.vld),
            .ids  (s_q.gid),
            .key  (lk_key[g]),
            .hit  (lk_hit[g]),
            .idx  (lk_idx[g])
        );
    end

    // Execute-done is applied ahead of dispatch
    logic            ex_done;
    logic [ID_W-1:0] cur_ld_x, cur_st_x, cur_bar_x;

    assign ex_done   = exec_valid && lk_hit[LK_EXEC] &&
                       (s_q.outst[lk_idx[LK_EXEC]] == OUT_W'(1));
    assign cur_ld_x  = (ex_done && s_q.cur_ld  == exec_gid) ? '0 : s_q.cur_ld;
    assign cur_st_x  = (ex_done && s_q.cur_st  == exec_gid) ? '0 : s_q.cur_st;
    assign cur_bar_x = (ex_done && s_q.cur_bar == exec_gid) ? '0 : s_q.cur_bar;

    // Free entry search over the registered table
    logic             free_any;
    logic [IDX_W-1:0] free_idx;

    always_comb begin
        free_any = 1'b0;
        free_idx = '0;
        for (int i = GROUPS - 1; i >= 0; i--) begin
            if (!s_q.vld[i]) begin
                free_any = 1'b1;
                free_idx = IDX_W'(i);
            end
        end
    end

    // Queue occupancy
    logic lq_full, sq_full;

    mot_slot_counter #(.DEPTH(LQ_DEPTH)) u_lq_cnt (
        .clk            (clk),
        .rst            (rst),
        .inc            (disp_accept && disp_load),
        .dec            (ret_valid && ret_load),
        .count          (lq_count),
        .full_after_dec (lq_full)
    );

    mot_slot_counter #(.DEPTH(SQ_DEPTH)) u_sq_cnt (
        .clk            (clk),
        .rst            (rst),
        .inc            (disp_accept && disp_store),
        .dec            (ret_valid && ret_store),
        .count          (sq_count),
        .full_after_dec (sq_full)
    );

    // Group decision
    dstat_e          dec_status;
    logic            dec_open;
    logic [ID_W-1:0] dep_a, dep_b;

    mot_group_decider #(.ID_W(ID_W)) u_decider (
        .is_load  (disp_load),
        .is_store (disp_store),
        .is_bar   (disp_barrier),
        .no_alias (no_alias),
        .cur_ld   (cur_ld_x),
        .cur_st   (cur_st_x),
        .cur_bar  (cur_bar_x),
        .lq_full  (lq_full),
        .sq_full  (sq_full),
        .free_any (free_any),
        .status   (dec_status),
        .open_new (dec_open),
        .dep_a    (dep_a),
        .dep_b    (dep_b)
    );

    assign lk_key[LK_EXEC] = exec_gid;
    assign lk_key[LK_JOIN] = cur_ld_x;
    assign lk_key[LK_DEPA] = dep_a;
    assign lk_key[LK_DEPB] = dep_b;
    assign lk_key[LK_QRY]  = qry_gid;

    assign disp_accept = disp_valid && (dec_status == DS_OK);
    assign disp_status = dec_status;
    assign disp_new    = dec_open;
    assign disp_gid    = dec_open ? s_q.next_id : cur_ld_x;
    assign qry_live    = lk_hit[LK_QRY];
    assign qry_ready   = lk_hit[LK_QRY] && (s_q.npred[lk_idx[LK_QRY]] == '0);

    // Next-state computation
    always_comb begin
        logic [GROUPS-1:0] pred_mask;
        logic [IDX_W-1:0]  ex_idx;
        s_d       = s_q;
        ex_idx    = lk_idx[LK_EXEC];
        pred_mask = '0;
        if (lk_hit[LK_DEPA]) pred_mask[lk_idx[LK_DEPA]] = 1'b1;
        if (lk_hit[LK_DEPB]) pred_mask[lk_idx[LK_DEPB]] = 1'b1;

        if (exec_valid && lk_hit[LK_EXEC]) begin
            s_d.outst[ex_idx] = s_q.outst[ex_idx] - OUT_W'(1);
            if (ex_done) begin
                s_d.vld[ex_idx]  = 1'b0;
                s_d.succ[ex_idx] = '0;
                for (int j = 0; j < GROUPS; j++) begin
                    if (s_q.succ[ex_idx][j]) s_d.npred[j] = s_q.npred[j] - PRED_W'(1);
                end
            end
        end
        s_d.cur_ld  = cur_ld_x;
        s_d.cur_st  = cur_st_x;
        s_d.cur_bar = cur_bar_x;

        if (disp_accept) begin
            if (dec_open) begin
                s_d.vld[free_idx]   = 1'b1;
                s_d.gid[free_idx]   = s_q.next_id;
                s_d.outst[free_idx] = OUT_W'(1);
                s_d.npred[free_idx] = PRED_W'($countones(pred_mask));
                s_d.succ[free_idx]  = '0;
                for (int j = 0; j < GROUPS; j++) begin
                    s_d.succ[j][free_idx] = pred_mask[j];
                end
                s_d.next_id = s_q.next_id + ID_W'(1);
                if (disp_store) begin
                    s_d.cur_st = s_q.next_id;
                    if (disp_load) begin
                        s_d.cur_ld = s_q.next_id;
                        if (disp_barrier) s_d.cur_bar = s_q.next_id;
                    end
                end else begin
                    s_d.cur_ld = s_q.next_id;
                    if (disp_barrier) s_d.cur_bar = s_q.next_id;
                end
            end else if (lk_hit[LK_JOIN]) begin
                s_d.outst[lk_idx[LK_JOIN]] = s_d.outst[lk_idx[LK_JOIN]] + OUT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q         <= '0;
            s_q.next_id <= ID_W'(1);
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/mot_checker.sv
module mot_checker #(
    parameter int LQ_DEPTH = 12,
    parameter int SQ_DEPTH = 12,
    parameter int ID_W     = 16
) (
    input logic                          clk,
    input logic                          rst,
    input logic                          disp_valid,
    input logic                          disp_load,
    input logic                          disp_store,
    input logic                          disp_barrier,
    input logic                          disp_accept,
    input logic [1:0]                    disp_status,
    input logic                          disp_new,
    input logic [ID_W-1:0]               disp_gid,
    input logic                          ret_valid,
    input logic                          ret_load,
    input logic [$clog2(LQ_DEPTH+1)-1:0] lq_count,
    input logic [$clog2(SQ_DEPTH+1)-1:0] sq_count
);
    AST_LQ_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        lq_count <= ($clog2(LQ_DEPTH+1))'(LQ_DEPTH)); // R1
    AST_SQ_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        sq_count <= ($clog2(SQ_DEPTH+1))'(SQ_DEPTH)); // R1
    AST_LQ_FULL_FIRST: assert property (@(posedge clk) disable iff (rst)
        (disp_valid && disp_load && lq_count == ($clog2(LQ_DEPTH+1))'(LQ_DEPTH)
         && !(ret_valid && ret_load)) |-> disp_status == 2'd1); // R1
    AST_COUNTS_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!disp_accept && !ret_valid) |=> ($stable(lq_count) && $stable(sq_count))); // R2
    AST_ID_RISES: assert property (@(posedge clk) disable iff (rst)
        (disp_accept && disp_new) |=> (!(disp_accept && disp_new) || disp_gid > $past(disp_gid))); // R3
    AST_STORE_OPENS: assert property (@(posedge clk) disable iff (rst)
        (disp_accept && disp_store) |-> disp_new); // R4
    AST_BARRIER_OPENS: assert property (@(posedge clk) disable iff (rst)
        (disp_accept && disp_barrier) |-> disp_new); // R5
endmodule

bind mem_order_tracker mot_checker #(
    .LQ_DEPTH (LQ_DEPTH),
    .SQ_DEPTH (SQ_DEPTH),
    .ID_W     (ID_W)
) u_mot_checker (
    .clk          (clk),
    .rst          (rst),
    .disp_valid   (disp_valid),
    .disp_load    (disp_load),
    .disp_store   (disp_store),
    .disp_barrier (disp_barrier),
    .disp_accept  (disp_accept),
    .disp_status  (disp_status),
    .disp_new     (disp_new),
    .disp_gid     (disp_gid),
    .ret_valid    (ret_valid),
    .ret_load     (ret_load),
    .lq_count     (lq_count),
    .sq_count     (sq_count)
);

// File: tb/mem_order_tracker_bench.sv
module mem_order_tracker_bench;
    localparam int LQ = 12;
    localparam int SQ = 12;
    localparam int NG = 16;
    localparam int IW = 16;
    localparam int MAXID = 8192;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic na = 1'b0;
    logic dv = 1'b0, dl = 1'b0, ds = 1'b0, db = 1'b0;
    logic ev = 1'b0, rv = 1'b0, rl = 1'b0, rs = 1'b0;
    logic [IW-1:0] eg = '0, qg = '0;
    logic disp_accept, disp_new, qry_live, qry_ready;
    logic [1:0] disp_status;
    logic [IW-1:0] disp_gid;
    logic [3:0] lq_count, sq_count;

    always #5 clk = ~clk;

    mem_order_tracker #(.LQ_DEPTH(LQ), .SQ_DEPTH(SQ), .GROUPS(NG), .ID_W(IW)) u_mem_order_tracker (
        .clk(clk), .rst(rst), .no_alias(na),
        .disp_valid(dv), .disp_load(dl), .disp_store(ds), .disp_barrier(db),
        .disp_accept(disp_accept), .disp_status(disp_status), .disp_new(disp_new),
        .disp_gid(disp_gid), .exec_valid(ev), .exec_gid(eg),
        .ret_valid(rv), .ret_load(rl), .ret_store(rs),
        .qry_gid(qg), .qry_live(qry_live), .qry_ready(qry_ready),
        .lq_count(lq_count), .sq_count(sq_count)
    );

    int checks = 0, errors = 0;
    bit done = 0;

    // reference model
    bit m_live[MAXID];
    int m_outs[MAXID], m_p0[MAXID], m_p1[MAXID], m_kind[MAXID];
    int m_cur_ld, m_cur_st, m_cur_bar, m_next, m_lq, m_sq, m_nlive, m_low;
    int pool[3];
    int last_status, last_gid, last_new, last_qlive, last_qready;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic bit m_ready(input int id);
        if (id <= 0 || id >= MAXID || !m_live[id]) return 0;
        if (m_p0[id] != 0 && m_live[m_p0[id]]) return 0;
        if (m_p1[id] != 0 && m_live[m_p1[id]]) return 0;
        return 1;
    endfunction

    task automatic do_reset();
        rst = 1'b1;
        {dv, dl, ds, db, ev, rv, rl, rs} = '0;
        repeat (3) @(negedge clk);
        for (int i = 0; i < MAXID; i++) begin
            m_live[i] = 0; m_outs[i] = 0; m_p0[i] = 0; m_p1[i] = 0; m_kind[i] = 0;
        end
        m_cur_ld = 0; m_cur_st = 0; m_cur_bar = 0; m_next = 1;
        m_lq = 0; m_sq = 0; m_nlive = 0; m_low = 1;
        pool[0] = 0; pool[1] = 0; pool[2] = 0;
        rst = 1'b0;
    endtask

    task automatic step(input bit a_dv, input bit a_dl, input bit a_ds, input bit a_db,
                        input bit a_ev, input int a_eg,
                        input bit a_rv, input bit a_rl, input bit a_rs, input int a_qg);
        bit open;
        int exp_st, nlive_pre, id;
        dv = a_dv; dl = a_dl; ds = a_ds; db = a_db;
        ev = a_ev; eg = IW'(a_eg); rv = a_rv; rl = a_rl; rs = a_rs; qg = IW'(a_qg);
        #1;
        chk(int'(lq_count) == m_lq, "R2 load count", int'(lq_count), m_lq);
        chk(int'(sq_count) == m_sq, "R2 store count", int'(sq_count), m_sq);
        chk(qry_live == m_live[a_qg], "R8 query live", int'(qry_live), int'(m_live[a_qg]));
        chk(qry_ready == m_ready(a_qg), "R6 query ready", int'(qry_ready), int'(m_ready(a_qg)));
        last_qlive = int'(qry_live); last_qready = int'(qry_ready);
        nlive_pre = m_nlive;
        if (a_ev) begin
            m_outs[a_eg]--;
            pool[m_kind[a_eg]]++;
            if (m_outs[a_eg] == 0) begin
                m_live[a_eg] = 0; m_nlive--;
                if (m_cur_ld == a_eg) m_cur_ld = 0;
                if (m_cur_st == a_eg) m_cur_st = 0;
                if (m_cur_bar == a_eg) m_cur_bar = 0;
                while (m_low < m_next && !m_live[m_low]) m_low++;
            end
        end
        if (a_rv) begin
            if (a_rl) m_lq--;
            if (a_rs) m_sq--;
        end
        last_status = int'(disp_status); last_gid = int'(disp_gid); last_new = int'(disp_new);
        if (a_dv) begin
            open = a_ds || a_db || m_cur_ld == 0 || m_cur_ld <= m_cur_st || m_cur_ld <= m_cur_bar;
            if (a_dl && m_lq == LQ) exp_st = 1;
            else if (a_ds && m_sq == SQ) exp_st = 2;
            else if (open && nlive_pre == NG) exp_st = 3;
            else exp_st = 0;
            chk(int'(disp_status) == exp_st, exp_st == 3 ? "R9 status" : "R1 status",
                int'(disp_status), exp_st);
            if (exp_st == 0) begin
                chk(disp_accept == 1'b1, "R1 accept", int'(disp_accept), 1);
                chk(int'(disp_new) == int'(open), "R5 new group", int'(disp_new), int'(open));
                if (a_dl) m_lq++;
                if (a_ds) m_sq++;
                if (open) begin
                    id = m_next; m_next++;
                    m_live[id] = 1; m_outs[id] = 1; m_nlive++;
                    m_kind[id] = (a_dl && a_ds) ? 2 : (a_ds ? 1 : 0);
                    if (a_ds) begin
                        m_p0[id] = m_cur_st;
                        m_p1[id] = (m_cur_ld > m_cur_bar) ? m_cur_ld : m_cur_bar;
                        m_cur_st = id;
                        if (a_dl) begin
                            m_cur_ld = id;
                            if (a_db) m_cur_bar = id;
                        end
                    end else begin
                        m_p0[id] = na ? 0 : m_cur_st;
                        m_p1[id] = m_cur_bar;
                        m_cur_ld = id;
                        if (a_db) m_cur_bar = id;
                    end
                end else begin
                    id = m_cur_ld;
                    m_outs[id]++;
                end
                chk(int'(disp_gid) == id, "R3 group id", int'(disp_gid), id);
            end
        end
        @(posedge clk);
        @(negedge clk);
        {dv, ev, rv} = '0;
    endtask

    task automatic idle(input int q);
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, q);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int cand[64];
        int nc, r, k, q;
        bit xl, xs, xb, xe, xr, xrl, xrs;
        int xg;
        void'($urandom(32'd7731));
        @(negedge clk);
        do_reset();

        // reset state
        idle(1);
        chk(lq_count == 0 && sq_count == 0, "R2 reset counts", int'(lq_count), 0);
        chk(last_qlive == 0, "R8 nothing live after reset", last_qlive, 0);

        // grouping and dependencies
        step(1, 1, 0, 0, 0, 0, 0, 0, 0, 0);
        chk(last_gid == 1 && last_new == 1, "R3 first id is 1", last_gid, 1);
        step(1, 1, 0, 0, 0, 0, 0, 0, 0, 0);
        chk(last_gid == 1 && last_new == 0, "R5 load joins group", last_gid, 1);
        step(1, 0, 1, 0, 0, 0, 0, 0, 0, 0);
        chk(last_gid == 2 && last_new == 1, "R4 store opens group", last_gid, 2);
        step(1, 1, 0, 0, 0, 0, 0, 0, 0, 0);
        chk(last_gid == 3 && last_new == 1, "R5 load after store opens", last_gid, 3);
        idle(2);
        chk(last_qready == 0, "R4 store waits on load group", last_qready, 0);
        step(0, 0, 0, 0, 1, 1, 0, 0, 0, 3);
        step(0, 0, 0, 0, 1, 1, 0, 0, 0, 1);
        idle(1);
        chk(last_qlive == 0, "R8 group freed", last_qlive, 0);
        idle(2);
        chk(last_qready == 1, "R6 store released", last_qready, 1);
        idle(3);
        chk(last_qready == 0, "R6 load waits on store", last_qready, 0);
        step(0, 0, 0, 0, 1, 2, 0, 0, 0, 3);
        step(1, 1, 0, 0, 1, 3, 0, 0, 0, 0);
        chk(last_gid == 4 && last_new == 1, "R10 execute before dispatch", last_gid, 4);
        idle(0);
        chk(lq_count == 4 && sq_count == 1, "R2 execute keeps counts", int'(lq_count), 4);
        step(0, 0, 0, 0, 0, 0, 1, 1, 0, 0);
        idle(0);
        chk(lq_count == 3, "R2 retire frees slot", int'(lq_count), 3);

        // no-alias mode
        do_reset();
        na = 1'b1;
        step(1, 0, 1, 0, 0, 0, 0, 0, 0, 0);
        step(1, 1, 0, 0, 0, 0, 0, 0, 0, 0);
        idle(2);
        chk(last_qready == 1, "R7 load skips store edge", last_qready, 1);
        na = 1'b0;

        // queue limits
        do_reset();
        for (int i = 0; i < LQ; i++) step(1, 1, 0, 0, 0, 0, 0, 0, 0, 0);
        step(1, 1, 0, 0, 0, 0, 0, 0, 0, 0);
        chk(last_status == 1, "R1 load queue full", last_status, 1);
        step(1, 1, 1, 0, 0, 0, 0, 0, 0, 0);
        chk(last_status == 1, "R1 load full reported first", last_status, 1);
        for (int i = 0; i < SQ; i++) step(1, 0, 1, 0, 0, 0, 0, 0, 0, 0);
        step(1, 0, 1, 0, 0, 0, 0, 0, 0, 0);
        chk(last_status == 2, "R1 store queue full", last_status, 2);
        step(1, 0, 1, 0, 0, 0, 1, 0, 1, 0);
        chk(last_status == 0, "R1 same-cycle retire frees", last_status, 0);

        // table full
        do_reset();
        for (int i = 0; i < 8; i++) step(1, 1, 0, 1, 0, 0, 0, 0, 0, 0);
        for (int i = 0; i < 8; i++) step(1, 0, 1, 0, 0, 0, 0, 0, 0, 0);
        step(1, 1, 0, 1, 0, 0, 0, 0, 0, 0);
        chk(last_status == 3, "R9 table full", last_status, 3);
        step(1, 1, 0, 1, 1, 1, 0, 0, 0, 0);
        chk(last_status == 3, "R9 freed entry not reused same cycle", last_status, 3);
        step(1, 1, 0, 1, 0, 0, 0, 0, 0, 0);
        chk(last_status == 0 && last_gid == 17, "R9 entry reused", last_gid, 17);

        // random traffic
        do_reset();
        for (int cyc = 0; cyc < 3000; cyc++) begin
            na = (cyc >= 1500);
            r = $urandom % 8;
            xl = (r <= 3) || (r == 6) || (r == 7);
            xs = (r >= 4) && (r <= 6);
            xb = (r == 7) || (xs && ($urandom % 6 == 0));
            nc = 0;
            for (int id = m_low; id < m_next && nc < 64; id++)
                if (m_ready(id)) begin cand[nc] = id; nc++; end
            xe = (nc > 0) && ($urandom % 10 < 7);
            xg = (nc > 0) ? cand[$urandom % nc] : 0;
            xr = 0; xrl = 0; xrs = 0;
            if ((pool[0] + pool[1] + pool[2]) > 0 && ($urandom % 2 == 0)) begin
                k = $urandom % 3;
                while (pool[k] == 0) k = (k + 1) % 3;
                pool[k]--;
                xr = 1; xrl = (k != 1); xrs = (k != 0);
            end
            q = m_low + int'($urandom % 24);
            if (q >= MAXID) q = 0;
            step(($urandom % 4) != 0, xl, xs, xb, xe, xg, xr, xrl, xrs, q);
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule